// File: doc/BRIEF.md
# Distributed Priority Bus Arbitration Unit

This block is the arbitration agent that sits beside one would-be master on a shared parallel bus that has no central arbiter. Every master carries its own copy. The copies compete over seven open-collector priority lines, a shared bus-request line and a shared grant-acknowledge line. A central processor answers the bus request with a bus grant, and that grant generator lies outside this block. The local side of the unit is a simple request/proceed pair. The master raises its request and keeps it high for as long as it wants the bus. The unit raises proceed and enables the master's tri-state bus drivers while it owns the bus.

Arbitration is first come, first served. A unit may join only while the bus is quiet, so late arrivals wait for the next round, and priority only settles ties between units that joined together. The result of the priority network is captured once, on the first clock edge that sees the grant. The captured winner takes the bus at the first edge after the current transfer cycle has finished. It then keeps the bus until its own master lets go, and no higher-priority request can force it off.

All bus lines are active-low, wired-AND signals. The unit samples the resolved line levels and drives each line it owns through a "pull" output, where 1 means pull the line low.

Top module: `pba_unit`

## Requirements
- R1: While reset is held, every pull output, the driver enable and proceed are 0.
- R2: The unit starts a request only on a clock edge where its local request is 1 and bus request, bus grant and grant-acknowledge all read 1 (inactive). From that edge it pulls both the bus request and its own priority line, together.
- R3: Priority line k (1 to 7) is bit k-1 of the priority input, and a higher k wins. On the first edge after bus grant reads 0, the unit captures whether its own line is active with no higher-numbered line active. Only a unit that captured a win may take the bus in that round.
- R4: A winning unit pulls grant-acknowledge, enables its drivers and raises proceed on the first edge where address strobe, transfer acknowledge and grant-acknowledge all read 1. When the bus is idle and no one else competes, proceed is high after the third edge following the edge that started the request.
- R5: A requesting unit that sees grant-acknowledge at 0 releases its bus-request and priority pulls at that edge. The owner has already released its own pulls when it took the bus.
- R6: While it owns the bus and its local request stays 1, the unit keeps grant-acknowledge, the driver enable and proceed asserted, whatever other masters request.
- R7: An owner whose local request is 0 releases grant-acknowledge, the driver enable and proceed on the first edge where address strobe and transfer acknowledge both read 1, and not before.
- R8: A unit whose local request drops before it takes the bus releases its bus-request and priority pulls at the next edge.
- R9: A unit whose request arrives while another unit already holds the bus request does not join that round, even with a higher priority, and the earlier unit is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loc_req_i | input | 1 | Local master wants the bus; held until done |
| loc_go_o | output | 1 | Proceed: local master owns the bus |
| bus_br_n_i | input | 1 | Resolved bus request line (active low) |
| bus_bg_n_i | input | 1 | Resolved bus grant line (active low) |
| bus_bgack_n_i | input | 1 | Resolved grant-acknowledge line (active low) |
| bus_as_n_i | input | 1 | Resolved address strobe (active low) |
| bus_dtack_n_i | input | 1 | Resolved transfer acknowledge (active low) |
| bus_prio_n_i | input | NUM_LINES | Resolved priority lines, line k at bit k-1 (active low) |
| br_pull_o | output | 1 | 1 pulls the bus request line low |
| prio_pull_o | output | 1 | 1 pulls this unit's own priority line low |
| bgack_pull_o | output | 1 | 1 pulls grant-acknowledge low |
| drv_en_o | output | 1 | Enables the master's tri-state bus drivers |

## Verification
A wrong captured win shows at the ports within one edge of the address strobe going idle. Either two units pull grant-acknowledge and raise proceed together, or no unit does and the remaining requesters hang with the bus request held. A sequencer stuck in a requesting state leaves the bus-request pull set after grant-acknowledge falls, which is visible one edge later. An owner that lets go too early or too late shows as proceed changing while address strobe is low, or staying high for an edge after the cycle went idle. The bench runs three units of different priority on a modelled wired-AND bus. It sweeps every combination of simultaneous requests and checks each grant order against the highest pending priority.

// File: rtl/pba_pkg.sv
package pba_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ARB  = 2'd2,
    ST_OWN  = 2'd3
  } arb_state_e;

  typedef struct packed {
    logic req_line;   // pull bus request and own priority line
    logic own_line;   // pull grant-acknowledge, drive, proceed
  } arb_out_t;

  function automatic arb_out_t decode_out(input arb_state_e s);
    arb_out_t o;
    o.req_line = (s == ST_REQ) || (s == ST_ARB);
    o.own_line = (s == ST_OWN);
    return o;
  endfunction

endpackage

// File: rtl/pba_prio_net.sv
module pba_prio_net #(
  parameter int NUM_LINES = 7,
  parameter int MY_LINE   = 7
) (
  input  logic [NUM_LINES-1:0] prio_n_i,
  output logic                 win_o
);
  localparam int OWN_IDX = MY_LINE - 1;

  logic [NUM_LINES-1:0] above_mask;
  logic [NUM_LINES-1:0] active;

  assign active = ~prio_n_i;

  // mask selects every line ranked above this unit
  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_mask
      assign above_mask[g] = (g > OWN_IDX);
    end
  endgenerate

  assign win_o = active[OWN_IDX] & ~|(active & above_mask);

endmodule

// File: rtl/pba_bus_sense.sv
module pba_bus_sense (
  input  logic br_n_i,
  input  logic bg_n_i,
  input  logic bgack_n_i,
  input  logic as_n_i,
  input  logic dtack_n_i,
  output logic start_ok_o,
  output logic grant_seen_o,
  output logic owner_seen_o,
  output logic cycle_idle_o
);
  // a new round may open only on a fully quiet arbitration bus
  assign start_ok_o   = br_n_i & bg_n_i & bgack_n_i;
  assign grant_seen_o = ~bg_n_i;
  assign owner_seen_o = ~bgack_n_i;
  // no transfer in flight: strobe and acknowledge both released
  assign cycle_idle_o = as_n_i & dtack_n_i;

endmodule

// File: rtl/pba_seq.sv
module pba_seq
  import pba_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic loc_req_i,
  input  logic start_ok_i,
  input  logic grant_seen_i,
  input  logic owner_seen_i,
  input  logic cycle_idle_i,
  input  logic win_i,
  output logic br_pull_o,
  output logic prio_pull_o,
  output logic ack_pull_o,
  output logic drv_en_o,
  output logic go_o
);
  arb_state_e state_q, state_d;
  arb_out_t   out_d;
  logic       win_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (loc_req_i && start_ok_i) state_d = ST_REQ;
      ST_REQ: begin
        if (!loc_req_i || owner_seen_i) state_d = ST_IDLE;
        else if (grant_seen_i)          state_d = ST_ARB;
      end
      ST_ARB: begin
        if (!loc_req_i || owner_seen_i)  state_d = ST_IDLE;
        else if (win_q && cycle_idle_i)  state_d = ST_OWN;
      end
      ST_OWN: if (!loc_req_i && cycle_idle_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign out_d = decode_out(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      win_q       <= 1'b0;
      br_pull_o   <= 1'b0;
      prio_pull_o <= 1'b0;
      ack_pull_o  <= 1'b0;
      drv_en_o    <= 1'b0;
      go_o        <= 1'b0;
    end else begin
      state_q <= state_d;
      // capture the priority result once, on the first edge seeing the grant
      if (state_q == ST_REQ && grant_seen_i) win_q <= win_i;
      else if (state_d == ST_IDLE)           win_q <= 1'b0;
      br_pull_o   <= out_d.req_line;
      prio_pull_o <= out_d.req_line;
      ack_pull_o  <= out_d.own_line;
      drv_en_o    <= out_d.own_line;
      go_o        <= out_d.own_line;
    end
  end

  // R2
  req_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(br_pull_o) |-> $past(start_ok_i && loc_req_i));

  // R4
  take_bus_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_pull_o) |-> $past(cycle_idle_i && !owner_seen_i && loc_req_i && win_q));

  // R5
  back_off_chk: assert property (@(posedge clk) disable iff (rst)
    (br_pull_o && owner_seen_i) |=> (!br_pull_o && !prio_pull_o));

  // R6
  no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pull_o && loc_req_i) |=> (ack_pull_o && drv_en_o && go_o));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pull_o && !loc_req_i && cycle_idle_i) |=> (!ack_pull_o && !drv_en_o && !go_o));

  // R7
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pull_o && !cycle_idle_i) |=> ack_pull_o);

  // R8
  withdraw_chk: assert property (@(posedge clk) disable iff (rst)
    (br_pull_o && !loc_req_i) |=> !br_pull_o);

endmodule

// File: rtl/pba_unit.sv
module pba_unit #(
  parameter int NUM_LINES = 7,
  parameter int MY_LINE   = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 loc_req_i,
  output logic                 loc_go_o,
  input  logic                 bus_br_n_i,
  input  logic                 bus_bg_n_i,
  input  logic                 bus_bgack_n_i,
  input  logic                 bus_as_n_i,
  input  logic                 bus_dtack_n_i,
  input  logic [NUM_LINES-1:0] bus_prio_n_i,
  output logic                 br_pull_o,
  output logic                 prio_pull_o,
  output logic                 bgack_pull_o,
  output logic                 drv_en_o
);
  logic start_ok, grant_seen, owner_seen, cycle_idle, win;

  pba_bus_sense u_sense (
    .br_n_i       (bus_br_n_i),
    .bg_n_i       (bus_bg_n_i),
    .bgack_n_i    (bus_bgack_n_i),
    .as_n_i       (bus_as_n_i),
    .dtack_n_i    (bus_dtack_n_i),
    .start_ok_o   (start_ok),
    .grant_seen_o (grant_seen),
    .owner_seen_o (owner_seen),
    .cycle_idle_o (cycle_idle)
  );

  pba_prio_net #(
    .NUM_LINES (NUM_LINES),
    .MY_LINE   (MY_LINE)
  ) u_net (
    .prio_n_i (bus_prio_n_i),
    .win_o    (win)
  );

  pba_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .loc_req_i    (loc_req_i),
    .start_ok_i   (start_ok),
    .grant_seen_i (grant_seen),
    .owner_seen_i (owner_seen),
    .cycle_idle_i (cycle_idle),
    .win_i        (win),
    .br_pull_o    (br_pull_o),
    .prio_pull_o  (prio_pull_o),
    .ack_pull_o   (bgack_pull_o),
    .drv_en_o     (drv_en_o),
    .go_o         (loc_go_o)
  );

endmodule

// File: tb/pba_unit_test.sv
`timescale 1ns/1ps
module pba_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [2:0] req;            // 0: line 2, 1: line 4 (uut), 2: line 6
  logic       as_n, dtack_n, ext_br, ext_bgack;
  logic [6:0] ext_prio;
  logic       bg_n;
  logic       br_n, bgack_n;
  logic [6:0] prio_n;
  logic [2:0] go, brp, pp, ap, de;

  int n_tests = 0;
  int n_fail  = 0;

  assign br_n    = ~(|brp | ext_br);
  assign bgack_n = ~(|ap | ext_bgack);
  assign prio_n  = ~({1'b0, pp[2], 1'b0, pp[1], 1'b0, pp[0], 1'b0} | ext_prio);

  // central processor grant model
  always_ff @(posedge clk) begin
    if (rst) bg_n <= 1'b1;
    else     bg_n <= ~(~br_n & bgack_n);
  end

  pba_unit #(.NUM_LINES(7), .MY_LINE(2)) u_lo (
    .clk(clk), .rst(rst), .loc_req_i(req[0]), .loc_go_o(go[0]),
    .bus_br_n_i(br_n), .bus_bg_n_i(bg_n), .bus_bgack_n_i(bgack_n),
    .bus_as_n_i(as_n), .bus_dtack_n_i(dtack_n), .bus_prio_n_i(prio_n),
    .br_pull_o(brp[0]), .prio_pull_o(pp[0]), .bgack_pull_o(ap[0]), .drv_en_o(de[0]));

  pba_unit #(.NUM_LINES(7), .MY_LINE(4)) uut (
    .clk(clk), .rst(rst), .loc_req_i(req[1]), .loc_go_o(go[1]),
    .bus_br_n_i(br_n), .bus_bg_n_i(bg_n), .bus_bgack_n_i(bgack_n),
    .bus_as_n_i(as_n), .bus_dtack_n_i(dtack_n), .bus_prio_n_i(prio_n),
    .br_pull_o(brp[1]), .prio_pull_o(pp[1]), .bgack_pull_o(ap[1]), .drv_en_o(de[1]));

  pba_unit #(.NUM_LINES(7), .MY_LINE(6)) u_hi (
    .clk(clk), .rst(rst), .loc_req_i(req[2]), .loc_go_o(go[2]),
    .bus_br_n_i(br_n), .bus_bg_n_i(bg_n), .bus_bgack_n_i(bgack_n),
    .bus_as_n_i(as_n), .bus_dtack_n_i(dtack_n), .bus_prio_n_i(prio_n),
    .br_pull_o(brp[2]), .prio_pull_o(pp[2]), .bgack_pull_o(ap[2]), .drv_en_o(de[2]));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_go(input int limit, output logic [2:0] got);
    got = 3'b000;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (|go) begin
        got = go;
        break;
      end
    end
  endtask

  task automatic settle();
    req = 3'b000;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [2:0] top_bit(input logic [2:0] m);
    if (m[2]) return 3'b100;
    if (m[1]) return 3'b010;
    if (m[0]) return 3'b001;
    return 3'b000;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] got;
    logic [2:0] pend;
    req = 3'b000; as_n = 1'b1; dtack_n = 1'b1;
    ext_br = 1'b0; ext_bgack = 1'b0; ext_prio = 7'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pulls", {brp, pp, ap}, 9'b0);
    check("R1 go/drive", {go, de}, 6'b0);
    rst = 1'b0;
    @(negedge clk);

    // R2/R4/R5 single requester timing
    req[1] = 1'b1;
    @(negedge clk);
    check("R2 br and prio together", {brp[1], pp[1], go[1]}, 3'b110);
    @(negedge clk);
    check("R4 no go after edge 1", go[1], 1'b0);
    @(negedge clk);
    check("R4 no go after edge 2", go[1], 1'b0);
    @(negedge clk);
    check("R4 owns after edge 3", {go[1], de[1], ap[1]}, 3'b111);
    check("R5 owner lines released", {brp[1], pp[1]}, 2'b00);

    // R6/R9 higher request while owned
    req[2] = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 owner kept", {go[1], ap[1]}, 2'b11);
    check("R9 late high stays out", brp[2], 1'b0);

    // R7 release waits for idle cycle
    as_n = 1'b0; req[1] = 1'b0;
    @(negedge clk);
    check("R7 held while strobe busy", go[1], 1'b1);
    as_n = 1'b1;
    @(negedge clk);
    check("R7 released", {go[1], de[1], ap[1]}, 3'b000);
    wait_go(12, got);
    check("R4 next master granted", got, 3'b100);
    settle();

    // R2 start gated by foreign grant-acknowledge
    ext_bgack = 1'b1; req[1] = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 no start while bgack low", brp[1], 1'b0);
    ext_bgack = 1'b0;
    @(negedge clk);
    check("R2 starts once quiet", {brp[1], pp[1]}, 2'b11);
    wait_go(12, got);
    check("R2 gated request granted", got, 3'b010);
    settle();

    // R4 take-over waits on strobe and acknowledge
    as_n = 1'b0; dtack_n = 1'b0; req[1] = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 waits for cycle end", {go[1], brp[1]}, 2'b01);
    as_n = 1'b1;
    @(negedge clk);
    check("R4 waits for dtack", go[1], 1'b0);
    dtack_n = 1'b1;
    @(negedge clk);
    check("R4 takes bus at idle edge", {go[1], de[1]}, 2'b11);
    settle();

    // R8 withdrawal from request state
    req[1] = 1'b1;
    @(negedge clk);
    check("R8 requesting", brp[1], 1'b1);
    req[1] = 1'b0;
    @(negedge clk);
    check("R8 withdrawn", {brp[1], pp[1]}, 2'b00);
    settle();

    // R8 loser withdraws during arbitration
    as_n = 1'b0;
    req = 3'b101;
    repeat (4) @(negedge clk);
    req[0] = 1'b0;
    @(negedge clk);
    check("R8 loser withdrawn", {brp[0], pp[0]}, 2'b00);
    check("R8 winner still requesting", brp[2], 1'b1);
    as_n = 1'b1;
    wait_go(12, got);
    check("R8 winner granted", got, 3'b100);
    settle();

    // R9 first come first served
    req[0] = 1'b1;
    @(negedge clk);
    req[2] = 1'b1;
    @(negedge clk);
    check("R9 late high not joined", brp[2], 1'b0);
    wait_go(12, got);
    check("R9 early low granted", got, 3'b001);
    req[0] = 1'b0;
    @(negedge clk);
    wait_go(12, got);
    check("R9 high served next", got, 3'b100);
    settle();

    // R3/R5 hidden higher master on line 7
    req[1] = 1'b1;
    @(negedge clk);
    ext_br = 1'b1; ext_prio = 7'b1000000;
    repeat (6) @(negedge clk);
    check("R3 loses to line 7", go[1], 1'b0);
    ext_bgack = 1'b1; ext_br = 1'b0; ext_prio = 7'b0;
    @(negedge clk);
    check("R5 backs off on bgack", {brp[1], pp[1]}, 2'b00);
    repeat (3) @(negedge clk);
    ext_bgack = 1'b0;
    wait_go(12, got);
    check("R3 wins after foreign release", got, 3'b010);
    settle();

    // R3 lower foreign line does not block
    req[1] = 1'b1;
    @(negedge clk);
    ext_br = 1'b1; ext_prio = 7'b0000001;
    wait_go(12, got);
    check("R3 beats line 1", got, 3'b010);
    ext_br = 1'b0; ext_prio = 7'b0;
    settle();

    // R3 sweep of every simultaneous request set
    for (int m = 1; m < 8; m++) begin
      req = m[2:0];
      pend = m[2:0];
      while (pend != 3'b000) begin
        wait_go(16, got);
        check($sformatf("R3 sweep mask %0d", m), got, top_bit(pend));
        pend = pend & ~top_bit(pend);
        req = pend;
        @(negedge clk);
      end
      settle();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule